// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block turns one erase request, given as a start byte address and a byte length, into the chain of serial-flash commands needed to clear that range. It first checks the request against the page geometry and the device capacity. It then walks the range one step at a time. Each step is either a single-page erase or an eight-page block erase, chosen from the alignment of the current page and from the pages still left. After every erase command the block polls the status register until the device reports ready, and only then moves on.

The block sits between a controller that asks for erases and a byte-level SPI engine. It drives chip select itself. It hands the engine one byte at a time through a request/acknowledge pair and takes the received byte back on the acknowledge. A programmable idle gap separates consecutive status polls. A poll limit bounds how long a step may wait for the device. The request ends with a one-cycle done pulse, or with a one-cycle error pulse if the request is rejected or a step times out.

Top module: `flash_erase_seq`

## Requirements
- R1: A request is rejected with a one-cycle `err` pulse and no SPI traffic when the start is not a whole multiple of `PAGE_BYTES`, when the length is not a whole multiple of `PAGE_BYTES`, or when start plus length is larger than `NUM_PAGES*PAGE_BYTES`.
- R2: A step uses block erase, opcode 0x50, when the current page index has its three low bits zero and at least eight pages remain.
- R3: Every other step uses page erase, opcode 0x81.
- R4: Each erase frame is exactly four bytes: the opcode, then device address bits 23:16, then device address bits 15:8, then 0x00. The device address is the page index shifted left by `PAGE_OFS`.
- R5: Chip select (`spi_cs_n`, active low) stays low for a whole frame and goes high once the frame ends. A byte request is only raised while chip select is low.
- R6: After each erase frame, the block sends status polls until one reports ready. Each poll is its own chip-select cycle of exactly two bytes: 0xD7, then one byte whose received value is the status. Status bit 7 high means ready; bits 6:0 are ignored.
- R7: Before every status poll, chip select stays high for at least `poll_gap` cycles.
- R8: If `MAX_POLLS` consecutive polls in one step all report not ready, the request ends with an `err` pulse after the last of those polls, and no further frame is sent.
- R9: After a step completes, the page index advances and the remaining length shrinks by eight pages for a block erase or by one page for a page erase, so the range is covered exactly once.
- R10: `done` pulses for exactly one cycle when the remaining length reaches zero. A zero-length request gives `done` with no SPI traffic. `done` and `err` are never high together, and `busy` is low whenever either is high.
- R11: A request that arrives while `busy` is high is ignored and does not change the erase frames sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request strobe, taken only when idle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Length in bytes |
| poll_gap | input | GAP_W | Minimum idle cycles before each status poll |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when the range has been erased |
| err | output | 1 | One-cycle pulse on a rejected request or a poll timeout |
| spi_cs_n | output | 1 | Device chip select, active low |
| xfer_req | output | 1 | Byte transfer request to the SPI engine |
| xfer_tx | output | 8 | Byte to be shifted out |
| xfer_ack | input | 1 | One-cycle pulse when the engine has finished the byte |
| xfer_rx | input | 8 | Byte shifted in, valid with `xfer_ack` |

## Verification
The assertions assume that the SPI engine raises `xfer_ack` only for one cycle, only while `xfer_req` is high, and never in two cycles back to back. The bench's engine model waits at least one cycle before acknowledging a byte and then stays idle for one cycle before it looks at the next byte, so every acknowledge matches exactly one presented byte. The assertions also assume that `req_valid` is a plain strobe that needs no handshake. The stimulus raises it for single cycles, including once while a request is in progress to exercise the ignore rule.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] OP_BLK_ERASE = 8'h50;
  localparam logic [7:0] OP_PG_ERASE  = 8'h81;
  localparam logic [7:0] OP_STATUS    = 8'hD7;
  localparam int         BLK_PAGES    = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_CMD,
    S_GAP,
    S_POLL_OP,
    S_POLL_RD
  } seq_state_t;
endpackage

// File: rtl/fe_step_plan.sv
module fe_step_plan
  import flash_erase_pkg::*;
#(
  parameter int PAGE_W   = 10,
  parameter int PAGE_OFS = 9
) (
  input  logic [PAGE_W-1:0] page_idx,
  input  logic [PAGE_W-1:0] rem_pages,
  output logic [7:0]        opcode,
  output logic [7:0]        addr_hi,
  output logic [7:0]        addr_mid,
  output logic [PAGE_W-1:0] step_pages
);
  localparam int WIDE_W = PAGE_W + PAGE_OFS;

  logic              blk_ok;
  logic [WIDE_W-1:0] wide_addr;
  logic [23:0]       dev_addr;
  logic [7:0]        unused_low;

  always_comb begin
    blk_ok     = (page_idx[2:0] == 3'd0) && (rem_pages >= PAGE_W'(BLK_PAGES));
    opcode     = blk_ok ? OP_BLK_ERASE : OP_PG_ERASE;
    step_pages = blk_ok ? PAGE_W'(BLK_PAGES) : PAGE_W'(1);
    wide_addr  = WIDE_W'(page_idx) << PAGE_OFS;
    dev_addr   = 24'(wide_addr);
    addr_hi    = dev_addr[23:16];
    addr_mid   = dev_addr[15:8];
    unused_low = dev_addr[7:0];
  end
endmodule

// File: rtl/fe_poll_timer.sv
module fe_poll_timer #(
  parameter int GAP_W     = 16,
  parameter int MAX_POLLS = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gap_load,
  input  logic [GAP_W-1:0] gap_len,
  output logic             gap_zero,
  input  logic             poll_clr,
  input  logic             poll_miss,
  output logic             poll_last
);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);

  logic [GAP_W-1:0]  gap_cnt;
  logic [POLL_W-1:0] poll_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
    end else if (gap_load) begin
      gap_cnt <= gap_len;
    end else if (gap_cnt != '0) begin
      gap_cnt <= gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || poll_clr) begin
      poll_cnt <= '0;
    end else if (poll_miss) begin
      poll_cnt <= poll_cnt + 1'b1;
    end
  end

  assign gap_zero  = (gap_cnt == '0);
  assign poll_last = (poll_cnt == POLL_W'(MAX_POLLS - 1));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int NUM_PAGES  = 512,
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_OFS   = 9,
  parameter int GAP_W      = 16,
  parameter int MAX_POLLS  = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  input  logic [GAP_W-1:0]  poll_gap,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              spi_cs_n,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx
);
  localparam int PAGE_W    = $clog2(NUM_PAGES + 1);
  localparam int DEV_BYTES = NUM_PAGES * PAGE_BYTES;

  seq_state_t        state;
  logic [PAGE_W-1:0] page_idx, rem_pages, step_pages;
  logic [1:0]        byte_idx;
  logic [7:0]        opcode, addr_hi, addr_mid;
  logic [ADDR_W:0]   end_sum;
  logic              bad_req, zero_len;
  logic              gap_load, gap_zero, poll_clr, poll_miss, poll_last;
  logic              frame_end, poll_end, ready;
  logic [6:0]        unused_rx;

  fe_step_plan #(.PAGE_W(PAGE_W), .PAGE_OFS(PAGE_OFS)) u_plan (
    .page_idx  (page_idx),
    .rem_pages (rem_pages),
    .opcode    (opcode),
    .addr_hi   (addr_hi),
    .addr_mid  (addr_mid),
    .step_pages(step_pages)
  );

  fe_poll_timer #(.GAP_W(GAP_W), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .gap_load (gap_load),
    .gap_len  (poll_gap),
    .gap_zero (gap_zero),
    .poll_clr (poll_clr),
    .poll_miss(poll_miss),
    .poll_last(poll_last)
  );

  function automatic logic [7:0] frame_byte(input logic [1:0] k,
                                            input logic [7:0] op,
                                            input logic [7:0] hi,
                                            input logic [7:0] mid);
    case (k)
      2'd0:    frame_byte = op;
      2'd1:    frame_byte = hi;
      2'd2:    frame_byte = mid;
      default: frame_byte = 8'h00;
    endcase
  endfunction

  always_comb begin
    end_sum   = {1'b0, req_addr} + {1'b0, req_len};
    bad_req   = ((req_addr % ADDR_W'(PAGE_BYTES)) != '0) ||
                ((req_len % ADDR_W'(PAGE_BYTES)) != '0) ||
                (end_sum > (ADDR_W+1)'(DEV_BYTES));
    zero_len  = (req_len == '0);
    ready     = xfer_rx[7];
    unused_rx = xfer_rx[6:0];
    frame_end = (state == S_CMD) && xfer_ack && (byte_idx == 2'd3);
    poll_end  = (state == S_POLL_RD) && xfer_ack;
    gap_load  = frame_end || (poll_end && !ready && !poll_last);
    poll_miss = poll_end && !ready && !poll_last;
    poll_clr  = (state == S_IDLE) || (poll_end && ready);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      page_idx  <= '0;
      rem_pages <= '0;
      byte_idx  <= '0;
      spi_cs_n  <= 1'b1;
      xfer_req  <= 1'b0;
      xfer_tx   <= 8'h00;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (bad_req) begin
              err <= 1'b1;
            end else if (zero_len) begin
              done <= 1'b1;
            end else begin
              page_idx  <= PAGE_W'(req_addr / ADDR_W'(PAGE_BYTES));
              rem_pages <= PAGE_W'(req_len / ADDR_W'(PAGE_BYTES));
              state     <= S_START;
            end
          end
        end
        S_START: begin
          spi_cs_n <= 1'b0;
          xfer_req <= 1'b1;
          xfer_tx  <= opcode;
          byte_idx <= 2'd0;
          state    <= S_CMD;
        end
        S_CMD: begin
          if (xfer_ack) begin
            if (byte_idx == 2'd3) begin
              xfer_req <= 1'b0;
              spi_cs_n <= 1'b1;
              state    <= S_GAP;
            end else begin
              byte_idx <= byte_idx + 2'd1;
              xfer_tx  <= frame_byte(byte_idx + 2'd1, opcode, addr_hi, addr_mid);
            end
          end
        end
        S_GAP: begin
          if (gap_zero) begin
            spi_cs_n <= 1'b0;
            xfer_req <= 1'b1;
            xfer_tx  <= OP_STATUS;
            state    <= S_POLL_OP;
          end
        end
        S_POLL_OP: begin
          if (xfer_ack) begin
            xfer_tx <= 8'h00;
            state   <= S_POLL_RD;
          end
        end
        S_POLL_RD: begin
          if (xfer_ack) begin
            xfer_req <= 1'b0;
            spi_cs_n <= 1'b1;
            if (ready) begin
              page_idx  <= page_idx + step_pages;
              rem_pages <= rem_pages - step_pages;
              if (rem_pages == step_pages) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end else begin
                state <= S_START;
              end
            end else if (poll_last) begin
              err   <= 1'b1;
              state <= S_IDLE;
            end else begin
              state <= S_GAP;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/fe_checker.sv
module fe_checker (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic err,
  input logic spi_cs_n,
  input logic xfer_req
);
  AST_REQ_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> !spi_cs_n);  // R5
  AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_cs_n);  // R5
  AST_CS_RISE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> !xfer_req);  // R5
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err));  // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R10
  AST_END_IS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !busy);  // R10
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);  // R8
endmodule

bind flash_erase_seq fe_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .spi_cs_n(spi_cs_n),
  .xfer_req(xfer_req)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int PB    = 264;
  localparam int OFS   = 9;
  localparam int MAXP  = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [23:0] req_len = '0;
  logic [15:0] poll_gap = '0;
  logic        busy, done, err, spi_cs_n, xfer_req;
  logic [7:0]  xfer_tx;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'h00;

  always #5 clk = ~clk;

  flash_erase_seq #(.MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .poll_gap(poll_gap), .busy(busy), .done(done),
    .err(err), .spi_cs_n(spi_cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [23:0] exp_q[$];
  logic [7:0]  frm[0:7];
  int frm_n = 0, busy_polls = 0, busy_left = 0;
  int erase_seen = 0, polls_seen = 0, hi_cnt = 0, last_gap = 0;
  logic prev_cs = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // SPI engine model: one byte per request, acknowledged after one cycle
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_req) begin
        @(negedge clk);
        if (frm_n == 1 && frm[0] == 8'hD7) begin
          xfer_rx = (busy_left == 0) ? 8'h80 : 8'h7F;
          if (busy_left > 0) busy_left--;
        end else begin
          xfer_rx = 8'hFF;
        end
        if (frm_n < 8) frm[frm_n] = xfer_tx;
        frm_n++;
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
      end
    end
  end

  // Monitor: frames close when chip select rises; scoreboard pop on erase frames
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!prev_cs && spi_cs_n && frm_n > 0) begin
          if (frm[0] == 8'hD7) begin
            polls_seen++;
            check(frm_n == 2, "R6 poll frame length", frm_n, 2);
            check(last_gap >= int'(poll_gap), "R7 gap before poll", last_gap, poll_gap);
          end else begin
            erase_seen++;
            busy_left = busy_polls;
            check(frm_n == 4 && frm[3] == 8'h00, "R4 frame length/pad", frm_n, 4);
            if (exp_q.size() == 0) begin
              check(0, "R11 unexpected erase frame", {frm[0], frm[1], frm[2]}, 0);
            end else begin
              logic [23:0] e;
              e = exp_q.pop_front();
              check(frm[0] == e[23:16], (e[23:16] == 8'h50) ? "R2 opcode" : "R3 opcode",
                    frm[0], e[23:16]);
              check({frm[1], frm[2]} == e[15:0], "R4 address bytes",
                    {frm[1], frm[2]}, e[15:0]);
            end
          end
          frm_n = 0;
        end
        if (prev_cs && !spi_cs_n) begin
          last_gap = hi_cnt;
          hi_cnt = 0;
        end else if (spi_cs_n) begin
          hi_cnt++;
        end
        prev_cs = spi_cs_n;
      end
    end
  end

  function automatic int push_expected(input int addr, input int len, input bit first_only);
    int p = addr / PB, r = len / PB, n = 0;
    while (r > 0) begin
      logic [7:0] op;
      int st;
      logic [23:0] a;
      if ((p % 8) == 0 && r >= 8) begin op = 8'h50; st = 8; end
      else begin op = 8'h81; st = 1; end
      a = 24'(p << OFS);
      exp_q.push_back({op, a[23:16], a[15:8]});
      n++;
      p += st;
      r -= st;
      if (first_only) break;
    end
    return n;
  endfunction

  // mode 0: completes, 1: rejected, 2: poll timeout
  task automatic run_req(input int addr, input int len, input int mode,
                         input int bp, input int gap, input bit inject);
    int steps;
    bit got_done = 0, got_err = 0;
    busy_polls = bp;
    poll_gap = 16'(gap);
    erase_seen = 0;
    polls_seen = 0;
    exp_q.delete();
    steps = (mode == 1) ? 0 : push_expected(addr, len, mode == 2);
    @(negedge clk);
    req_addr = 24'(addr);
    req_len = 24'(len);
    req_valid = 1'b1;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      @(negedge clk);
      if (inject && cyc == 30) begin
        check(busy == 1'b1, "R11 busy during request", busy, 1);
        req_addr = 24'(0);
        req_len = 24'(8 * PB);
        req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      if (done) got_done = 1;
      if (err) got_err = 1;
      if (done || err) break;
    end
    repeat (3) @(negedge clk);
    if (mode == 1) begin
      check(got_err && !got_done, "R1 reject flag", got_err, 1);
      check(erase_seen == 0 && polls_seen == 0, "R1 no traffic", erase_seen + polls_seen, 0);
    end else if (mode == 2) begin
      check(got_err && !got_done, "R8 timeout flag", got_err, 1);
      check(polls_seen == MAXP, "R8 poll count", polls_seen, MAXP);
      check(erase_seen == 1, "R8 no further frame", erase_seen, 1);
    end else begin
      check(got_done && !got_err, "R10 done flag", got_done, 1);
      check(erase_seen == steps, "R9 step count", erase_seen, steps);
      check(polls_seen == steps * (bp + 1), "R6 polls until ready", polls_seen, steps * (bp + 1));
    end
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    check(!busy && spi_cs_n, "R5 idle with CS high", {busy, spi_cs_n}, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!busy && !done && !err && spi_cs_n && !xfer_req, "R5 reset state",
          {busy, done, err, spi_cs_n, xfer_req}, 5'b00010);
    rst = 1'b0;
    run_req(0, 8 * PB, 0, 2, 3, 0);            // R2 single block
    run_req(3 * PB, 10 * PB, 0, 0, 0, 0);      // R3 unaligned start, pages only
    run_req(8 * PB, 17 * PB, 0, 1, 5, 1);      // R9 block, block, page; R11 inject
    run_req(1, PB, 1, 0, 0, 0);                // R1 misaligned start
    run_req(0, 100, 1, 0, 0, 0);               // R1 partial-page length
    run_req(510 * PB, 3 * PB, 1, 0, 0, 0);     // R1 past end of device
    run_req(504 * PB, 8 * PB, 0, 0, 2, 0);     // R2 last block, exact end
    run_req(0, 0, 0, 0, 0, 0);                 // R10 zero length
    run_req(16 * PB, PB, 2, 1000, 1, 0);       // R8 timeout
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule